// File: doc/BRIEF.md
# Active-Video Window Generator with Soft Edge Ramp

This block opens an active-video window on each video line and softens the start and end of that window. A pixel counter restarts on a line-start pulse. The window opens at a programmable start position and closes at a programmable end position. Inside the window, the 24-bit pixel data passes through unchanged. Outside it, a programmable blank colour replaces the data. At both edges the output crosses between the two values over a short linear ramp. Each 8-bit component is blended on its own.

A direction input sets the role of the shared window pin. In drive mode the block sends its internal window out, together with an output-enable. In gate mode the block treats the pin as an input. A high level on the pin lets the internal window act. A low level blanks the video whatever the internal window says. The pin can never open the window where the internal window is closed. Edges caused by the pin use the same ramp as the block's own edges. The pixel output is registered and appears two clocks after its input pixel.

Top module: `blank_ramp_win`

## Requirements
- R1: While reset is held, and on the first cycles after it, `pix_out` is 0 and `win_out` is 0.
- R2: A pixel presented with `line_start` high has index 0. Each later pixel has the next index, and the count saturates at its maximum. The internal window is open for pixels whose index is at least `win_start` and below `win_end`.
- R3: Once the ramp is at full level, `pix_out` equals the `pix_in` value presented two cycles earlier.
- R4: The ramp level starts at 0 and rises by one for each open pixel, up to 4. Each component (bits 23:16, 15:8 and 7:0) is output as floor((blank*(4-k) + pix*k)/4), where k is the level after that pixel.
- R5: After the window closes, the level falls by one per pixel (3/4, 2/4, 1/4, then blank). The blend uses the last pixel that was inside the window, not the current input.
- R6: When the level is 0, `pix_out` equals `blank_lvl` as presented two cycles earlier.
- R7: With `ext_dir`=0, `win_oe` is 1 and `win_out` shows the internal window for the pixel whose data is on `pix_out` in the same cycle.
- R8: With `ext_dir`=1, `win_oe` is 0, and a low `win_in` closes the effective window even where the internal window is open.
- R9: With `ext_dir`=1, a high `win_in` outside the internal window leaves the output at the blank level.
- R10: Edges caused by `win_in` follow the same 4-step ramp rules as R4 and R5.
- R11: The level is continuous across windows shorter than the ramp. It rises only as far as the open pixels allow, then falls from that level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_start | input | 1 | Marks the current pixel as index 0 of a line |
| pix_in | input | 24 | Input pixel, three 8-bit components |
| blank_lvl | input | 24 | Colour used while blanked |
| win_start | input | 12 | First pixel index inside the window |
| win_end | input | 12 | First pixel index after the window |
| ext_dir | input | 1 | 0: drive window pin, 1: pin is a gate input |
| win_in | input | 1 | Gate input from the window pin |
| win_out | output | 1 | Internal window, aligned with pix_out |
| win_oe | output | 1 | Output enable for the window pin |
| pix_out | output | 24 | Blended pixel, two cycles of latency |

## Verification
A pixel ramp with a different value in each component, against a dark blank colour, shows whether each component is blended on its own and whether the ramp down holds the last in-window pixel instead of tracking the input. A constant pixel against a full-white blank colour checks the blend in the opposite direction and its truncation. A two-pixel window checks that the level is continuous when a window is shorter than the ramp. In gate mode, a low pulse on the pin in mid-window separates a forced blank from the internal window edges. A pin held high across the whole line shows that the pin cannot widen the window.

// File: rtl/br_pkg.sv
package br_pkg;
   typedef enum logic {
      PIN_DRIVE = 1'b0,
      PIN_GATE  = 1'b1
   } pin_mode_e;
endpackage

// File: rtl/br_pos_gen.sv
module br_pos_gen #(
   parameter int CNT_W = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_start,
   input  logic [CNT_W-1:0] win_start,
   input  logic [CNT_W-1:0] win_end,
   output logic             win_int
);
   localparam logic [CNT_W-1:0] CNT_MAX = '1;

   initial begin
      if (CNT_W < 2) $error("CNT_W must be at least 2");
   end

   logic [CNT_W-1:0] pos_q;
   logic [CNT_W-1:0] cur;

   always_comb begin
      if (line_start)           cur = '0;
      else if (pos_q == CNT_MAX) cur = CNT_MAX;
      else                       cur = pos_q + 1'b1;
   end

   assign win_int = (cur >= win_start) && (cur < win_end);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pos_q <= CNT_MAX;
      else        pos_q <= cur;
   end

   AST_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      line_start |=> pos_q == '0); // R2
endmodule

// File: rtl/br_ramp_ctrl.sv
module br_ramp_ctrl #(
   parameter int PIX_W    = 24,
   parameter int RAMP_LEN = 4,
   parameter int LVL_W    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open,
   input  logic [PIX_W-1:0] pix_in,
   input  logic [PIX_W-1:0] blank_in,
   output logic [LVL_W-1:0] lvl_q,
   output logic [PIX_W-1:0] src_q,
   output logic [PIX_W-1:0] blank_q
);
   localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(RAMP_LEN);

   logic [LVL_W-1:0] lvl_d;

   always_comb begin
      if (open) lvl_d = (lvl_q == LVL_TOP) ? lvl_q : lvl_q + 1'b1;
      else      lvl_d = (lvl_q == '0)      ? lvl_q : lvl_q - 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q   <= '0;
         src_q   <= '0;
         blank_q <= '0;
      end else begin
         lvl_q   <= lvl_d;
         blank_q <= blank_in;
         if (open) src_q <= pix_in;
      end
   end

   AST_LVL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      lvl_q <= LVL_TOP); // R4
   AST_CLOSE_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
      !open |=> (lvl_q == '0) || (lvl_q < $past(lvl_q))); // R5
   AST_CLOSE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !open |=> $stable(src_q)); // R5
endmodule

// File: rtl/br_mix.sv
module br_mix #(
   parameter int COMP_W   = 8,
   parameter int NUM_COMP = 3,
   parameter int RAMP_LEN = 4,
   parameter int LVL_W    = 3
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [LVL_W-1:0]             lvl,
   input  logic [COMP_W*NUM_COMP-1:0]   src,
   input  logic [COMP_W*NUM_COMP-1:0]   blank,
   output logic [COMP_W*NUM_COMP-1:0]   pix_out
);
   localparam int PIX_W = COMP_W * NUM_COMP;
   localparam int SH    = $clog2(RAMP_LEN);
   localparam int MW    = COMP_W + LVL_W + 1;
   localparam logic [LVL_W-1:0] LVL_TOP = LVL_W'(RAMP_LEN);

   initial begin
      if ((1 << SH) != RAMP_LEN) $error("RAMP_LEN must be a power of two");
   end

   logic [PIX_W-1:0] mix_d;

   for (genvar g = 0; g < NUM_COMP; g++) begin : g_comp
      logic [MW-1:0] acc;
      assign acc = MW'(blank[g*COMP_W +: COMP_W]) * MW'(LVL_TOP - lvl)
                 + MW'(src[g*COMP_W +: COMP_W])   * MW'(lvl);
      assign mix_d[g*COMP_W +: COMP_W] = acc[SH +: COMP_W];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pix_out <= '0;
      else        pix_out <= mix_d;
   end

   AST_FULL_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      lvl == LVL_TOP |=> pix_out == $past(src)); // R3
   AST_BLANK_OUT: assert property (@(posedge clk) disable iff (!rst_n)
      lvl == '0 |=> pix_out == $past(blank)); // R6
endmodule

// File: rtl/blank_ramp_win.sv
module blank_ramp_win
   import br_pkg::*;
#(
   parameter int COMP_W   = 8,
   parameter int NUM_COMP = 3,
   parameter int CNT_W    = 12,
   parameter int RAMP_LEN = 4
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       line_start,
   input  logic [COMP_W*NUM_COMP-1:0] pix_in,
   input  logic [COMP_W*NUM_COMP-1:0] blank_lvl,
   input  logic [CNT_W-1:0]           win_start,
   input  logic [CNT_W-1:0]           win_end,
   input  logic                       ext_dir,
   input  logic                       win_in,
   output logic                       win_out,
   output logic                       win_oe,
   output logic [COMP_W*NUM_COMP-1:0] pix_out
);
   localparam int PIX_W = COMP_W * NUM_COMP;
   localparam int LVL_W = $clog2(RAMP_LEN + 1);

   initial begin
      if (COMP_W < 1 || NUM_COMP < 1) $error("component shape must be non-empty");
      if (RAMP_LEN < 1) $error("RAMP_LEN must be positive");
   end

   pin_mode_e        mode;
   logic             win_int;
   logic             win_eff;
   logic [1:0]       win_pipe;
   logic [LVL_W-1:0] lvl_s1;
   logic [PIX_W-1:0] src_s1;
   logic [PIX_W-1:0] blank_s1;

   assign mode    = pin_mode_e'(ext_dir);
   assign win_eff = win_int && ((mode == PIN_DRIVE) || win_in);
   assign win_oe  = (mode == PIN_DRIVE);
   assign win_out = win_pipe[1];

   br_pos_gen #(.CNT_W(CNT_W)) u_pos (
      .clk        (clk),
      .rst_n      (rst_n),
      .line_start (line_start),
      .win_start  (win_start),
      .win_end    (win_end),
      .win_int    (win_int)
   );

   br_ramp_ctrl #(.PIX_W(PIX_W), .RAMP_LEN(RAMP_LEN), .LVL_W(LVL_W)) u_ramp (
      .clk      (clk),
      .rst_n    (rst_n),
      .open     (win_eff),
      .pix_in   (pix_in),
      .blank_in (blank_lvl),
      .lvl_q    (lvl_s1),
      .src_q    (src_s1),
      .blank_q  (blank_s1)
   );

   br_mix #(.COMP_W(COMP_W), .NUM_COMP(NUM_COMP), .RAMP_LEN(RAMP_LEN), .LVL_W(LVL_W)) u_mix (
      .clk     (clk),
      .rst_n   (rst_n),
      .lvl     (lvl_s1),
      .src     (src_s1),
      .blank   (blank_s1),
      .pix_out (pix_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) win_pipe <= '0;
      else        win_pipe <= {win_pipe[0], win_int};
   end

   AST_GATE_BLANKS: assert property (@(posedge clk) disable iff (!rst_n)
      (ext_dir && !win_in) |=> (lvl_s1 == '0) || (lvl_s1 < $past(lvl_s1))); // R8
   AST_PIN_NO_OPEN: assert property (@(posedge clk) disable iff (!rst_n)
      !win_int |=> (lvl_s1 == '0) || (lvl_s1 < $past(lvl_s1))); // R9
endmodule

// File: tb/blank_ramp_win_tb.sv
module blank_ramp_win_tb;
   localparam int RL = 4;
   localparam int PMAX = 4095;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        line_start = 1'b0;
   logic [23:0] pix_in = '0;
   logic [23:0] blank_lvl = '0;
   logic [11:0] win_start = '0;
   logic [11:0] win_end = '0;
   logic        ext_dir = 1'b0;
   logic        win_in = 1'b0;
   logic        win_out;
   logic        win_oe;
   logic [23:0] pix_out;

   always #10 clk = ~clk;

   blank_ramp_win u_dut (
      .clk(clk), .rst_n(rst_n), .line_start(line_start), .pix_in(pix_in),
      .blank_lvl(blank_lvl), .win_start(win_start), .win_end(win_end),
      .ext_dir(ext_dir), .win_in(win_in), .win_out(win_out), .win_oe(win_oe),
      .pix_out(pix_out)
   );

   int errors = 0;
   int checks = 0;

   int          m_pos = PMAX;
   int          m_lvl = 0;
   logic [23:0] m_last = '0;
   logic [23:0] e_pix1 = '0, e_pix2 = '0;
   logic        e_win1 = 1'b0, e_win2 = 1'b0;
   string       e_tag1 = "R1", e_tag2 = "R1";
   string       force_tag = "";

   task automatic chk(string tag, logic [23:0] act, logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_step();
      int cur, prev, k;
      logic wi, eff;
      logic [23:0] r;
      string tg;
      cur = line_start ? 0 : ((m_pos == PMAX) ? PMAX : m_pos + 1);
      m_pos = cur;
      wi = (cur >= int'(win_start)) && (cur < int'(win_end));
      eff = wi && (!ext_dir || win_in);
      prev = m_lvl;
      if (eff) m_lvl = (m_lvl < RL) ? m_lvl + 1 : RL;
      else     m_lvl = (m_lvl > 0) ? m_lvl - 1 : 0;
      if (eff) m_last = pix_in;
      for (int c = 0; c < 3; c++) begin
         k = (int'(blank_lvl[c*8 +: 8]) * (RL - m_lvl) + int'(m_last[c*8 +: 8]) * m_lvl) / RL;
         r[c*8 +: 8] = 8'(k);
      end
      if (m_lvl == RL)          tg = "R3";
      else if (m_lvl == 0)      tg = "R6";
      else if (m_lvl > prev)    tg = "R4";
      else                      tg = "R5";
      if (wi && cur == int'(win_start)) tg = "R2";
      if (force_tag != "") tg = force_tag;
      if (ext_dir && wi && !win_in) tg = "R8";
      e_pix1 = r;
      e_win1 = wi;
      e_tag1 = tg;
   endtask

   task automatic cycle(logic ls, logic [23:0] px, logic [23:0] bl, logic [11:0] ws,
                        logic [11:0] we, logic dir, logic wn);
      @(negedge clk);
      chk(e_tag2, pix_out, e_pix2);
      chk("R7", {23'd0, win_out}, {23'd0, e_win2});
      chk(ext_dir ? "R8" : "R7", {23'd0, win_oe}, {23'd0, !ext_dir});
      e_pix2 = e_pix1; e_win2 = e_win1; e_tag2 = e_tag1;
      line_start = ls; pix_in = px; blank_lvl = bl; win_start = ws; win_end = we;
      ext_dir = dir; win_in = wn;
      model_step();
   endtask

   task automatic run_line(int ws, int we, int n, logic [23:0] bl, int sel, logic dir,
                           int glo, int ghi, logic wn_def, string tg);
      logic [23:0] px;
      logic wn;
      force_tag = tg;
      for (int i = 0; i < n; i++) begin
         px = (sel == 0) ? {8'(i * 3 + 1), 8'(~i), 8'(i * 7 + 40)} : 24'h80FF40;
         wn = (i >= glo && i < ghi) ? 1'b0 : wn_def;
         cycle(i == 0, px, bl, 12'(ws), 12'(we), dir, wn);
      end
      force_tag = "";
   endtask

   initial begin
      #4_000_000;
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         chk("R1", pix_out, 24'h0);
         chk("R1", {23'd0, win_out}, 24'h0);
      end
      rst_n = 1'b1;
      model_step();
      // drive mode, varying pixels, dark blank
      run_line(10, 30, 40, 24'h102030, 0, 1'b0, -1, -1, 1'b0, "");
      // constant pixel, white blank
      run_line(4, 12, 20, 24'hFFFFFF, 1, 1'b0, -1, -1, 1'b0, "");
      // window shorter than the ramp: R11
      run_line(5, 7, 14, 24'h000000, 0, 1'b0, -1, -1, 1'b0, "R11");
      // gate mode, low pulse mid-window: R8 and R10
      run_line(6, 30, 36, 24'h204060, 0, 1'b1, 14, 20, 1'b1, "R10");
      // gate mode, pin held high across the whole line: R9
      run_line(10, 15, 30, 24'h0A0B0C, 1, 1'b1, -1, -1, 1'b1, "R9");
      // back to drive mode, trailing idle pixels
      run_line(3, 9, 16, 24'h55AA33, 0, 1'b0, -1, -1, 1'b0, "");
      for (int i = 0; i < 3; i++) cycle(1'b0, 24'h0, 24'h55AA33, 12'd3, 12'd9, 1'b0, 1'b0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule